// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into the column addresses that a synchronous DRAM controller presents for a read or write burst. When `start` is high at a rising edge the block captures a starting column, a length code and an ordering bit. From the next cycle it streams one column address per accepted beat on a valid/ready output. Fixed bursts of 2, 4 or 8 beats stay inside the naturally aligned block that holds the starting column. Their low bits either count upward and wrap, or follow an XOR ordering. A whole-page burst walks the row upward from the starting column, wraps at the end of the page, and runs until `stop` ends it.

The output is a stream. A beat transfers on a rising edge where `col_valid` and `col_ready` are both high. While `col_ready` is low the block holds the presented address and last flag unchanged, so back-pressure never drops or repeats a beat. A new accepted request replaces the running burst at once, whatever the state of `col_ready`. `stop` ends the running burst at once. The block does not check the request against the state of a DRAM bank. It does not delay the addresses by any read latency.

Top module: `burst_col_seq`

## Requirements
- R1: A synchronous active-high reset `rst` clears `col_valid`, `col_last` and `start_err` on the next edge and leaves the block idle.
- R2: The length code `start_len` decodes as 2'b00 = 2 beats, 2'b01 = 4 beats, 2'b10 = 8 beats and 2'b11 = whole page. `start_ilv` = 0 selects upward ordering and 1 selects XOR ordering.
- R3: Upward ordering, fixed length N: beat k has low bits (s + k) mod N, where s is the starting column's low log2(N) bits. Length 8 from offset 5 gives 5,6,7,0,1,2,3,4.
- R4: XOR ordering, fixed length N: beat k has low bits s XOR k. Length 8 from offset 5 gives 5,4,7,6,1,0,3,2. Length 4 from offset 1 gives 1,0,3,2.
- R5: In a fixed-length burst, every column bit above the low log2(N) bits equals the starting column for the whole burst.
- R6: A whole-page burst with upward ordering emits the starting column C, then C+1, C+2 and so on modulo 2^COL_W. It never raises `col_last` and continues until `stop`.
- R7: `col_last` is high exactly on the Nth beat of a fixed-length burst. After that beat transfers, `col_valid` is low.
- R8: A request with `start_ilv`=1 and `start_len`=2'b11 is refused. `start_err` is high for the single following cycle. The request emits no address and leaves any running burst as it was.
- R9: An accepted request during a running burst abandons that burst. The new burst's first column is presented on the next cycle.
- R10: While `col_valid` is high and `col_ready` is low, and no request or stop arrives, `col_addr` and `col_last` hold and `col_valid` stays high.
- R11: `stop` high at an edge without an accepted request ends the burst: `col_valid` is low in the next cycle, for fixed and whole-page bursts alike.
- R12: The cycle after an accepted request, `col_valid` is high and `col_addr` equals `start_col`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; captures the three fields below |
| start_col | input | COL_W | Starting column |
| start_len | input | 2 | Burst length code |
| start_ilv | input | 1 | 0 = upward ordering, 1 = XOR ordering |
| stop | input | 1 | Ends the running burst |
| col_valid | output | 1 | Column address valid |
| col_ready | input | 1 | Consumer accepts the presented column |
| col_addr | output | COL_W | Column address of the current beat |
| col_last | output | 1 | Current beat is the final one of a fixed burst |
| start_err | output | 1 | One-cycle flag for a refused request |

## Verification
The assertions assume that `start` and `stop` are never high in the same cycle as reset. They also assume a stalled beat is judged only when neither a request nor a stop arrives, since either one replaces what is presented. The upper-bit check applies only between two consecutive valid cycles of one fixed burst, which excludes cycles that follow a new request. The stimulus changes inputs only on falling edges. It holds `start` and `stop` low through reset and raises each of them for exactly one cycle.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [1:0] {
    BL_2    = 2'b00,
    BL_4    = 2'b01,
    BL_8    = 2'b10,
    BL_PAGE = 2'b11
  } blen_e;

  localparam int unsigned MAX_BLK_BITS = 3;

  typedef struct packed {
    blen_e len;
    logic  ilv;
  } burst_mode_t;

  function automatic logic [MAX_BLK_BITS-1:0] fixed_limit(blen_e len);
    case (len)
      BL_2:    return 3'd1;
      BL_4:    return 3'd3;
      default: return 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/burst_req_check.sv
module burst_req_check
  import burst_pkg::*;
(
  input  logic       start,
  input  logic [1:0] len_code,
  input  logic       ilv,
  output logic       accept,
  output logic       reject
);

  logic illegal_combo;

  always_comb begin
    illegal_combo = ilv && (blen_e'(len_code) == BL_PAGE);
    accept        = start && !illegal_combo;
    reject        = start && illegal_combo;
  end

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             stop,
  input  logic             ready,
  input  blen_e            len,
  output logic             busy,
  output logic [COL_W-1:0] idx,
  output logic             at_last
);

  logic             full_page;
  logic [COL_W-1:0] limit;
  logic             beat_done;

  always_comb begin
    full_page = (len == BL_PAGE);
    limit     = COL_W'(fixed_limit(len));
    at_last   = busy && !full_page && (idx == limit);
    beat_done = busy && ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (stop) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (beat_done) begin
      if (at_last) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  blen_e            len,
  input  logic             ilv,
  output logic [COL_W-1:0] addr
);

  localparam int BLK_W = MAX_BLK_BITS;

  logic [COL_W-1:0] wrap_mask;
  logic [COL_W-1:0] up_sum;
  logic [COL_W-1:0] xor_val;
  logic [COL_W-1:0] low_sel;
  logic             full_page;

  assign full_page = (len == BL_PAGE);

  // Each bit is inside the wrapping field when the length covers it.
  for (genvar b = 0; b < COL_W; b++) begin : g_mask
    if (b < BLK_W) begin : g_blk
      assign wrap_mask[b] = full_page || (int'(len) >= b);
    end else begin : g_upper
      assign wrap_mask[b] = full_page;
    end
  end

  always_comb begin
    up_sum  = base + idx;
    xor_val = base ^ idx;
    low_sel = ilv ? xor_val : up_sum;
    addr    = (base & ~wrap_mask) | (low_sel & wrap_mask);
  end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [1:0]       start_len,
  input  logic             start_ilv,
  input  logic             stop,
  output logic             col_valid,
  input  logic             col_ready,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last,
  output logic             start_err
);

  logic             accept;
  logic             reject;
  logic [COL_W-1:0] base_q;
  burst_mode_t      mode_q;
  logic             busy;
  logic [COL_W-1:0] idx;
  logic             at_last;
  logic             cur_full;

  burst_req_check u_check (
    .start    (start),
    .len_code (start_len),
    .ilv      (start_ilv),
    .accept   (accept),
    .reject   (reject)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= '0;
      mode_q    <= '{len: BL_2, ilv: 1'b0};
      start_err <= 1'b0;
    end else begin
      start_err <= reject;
      if (accept) begin
        base_q <= start_col;
        mode_q <= '{len: blen_e'(start_len), ilv: start_ilv};
      end
    end
  end

  assign cur_full = (mode_q.len == BL_PAGE);

  burst_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept),
    .stop    (stop),
    .ready   (col_ready),
    .len     (mode_q.len),
    .busy    (busy),
    .idx     (idx),
    .at_last (at_last)
  );

  burst_addr_gen #(.COL_W(COL_W)) u_addr (
    .base (base_q),
    .idx  (idx),
    .len  (mode_q.len),
    .ilv  (mode_q.ilv),
    .addr (col_addr)
  );

  assign col_valid = busy;
  assign col_last  = at_last;

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [1:0]       start_len,
  input logic             start_ilv,
  input logic             stop,
  input logic             col_valid,
  input logic             col_ready,
  input logic [COL_W-1:0] col_addr,
  input logic             col_last,
  input logic             start_err,
  input logic             cur_full
);

  logic bad_req;
  assign bad_req = start && start_ilv && (start_len == 2'b11);

  AST_IDLE_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !col_valid && !col_last && !start_err); // R1

  AST_ACCEPT_EMITS: assert property (@(posedge clk) disable iff (rst)
    start && !bad_req |=> col_valid); // R12

  AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (rst)
    col_last |-> col_valid); // R7

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
    col_valid && col_ready && col_last && !start |=> !col_valid); // R7

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    col_valid && !col_ready && !start && !stop |=>
      col_valid && $stable(col_addr) && $stable(col_last)); // R10

  AST_REFUSE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    bad_req |=> start_err); // R8

  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    start_err |-> $past(bad_req)); // R8

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (rst)
    stop && !start |=> !col_valid); // R11

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    col_valid && $past(col_valid) && !$past(start) && !cur_full |->
      col_addr[COL_W-1:3] == $past(col_addr[COL_W-1:3])); // R5

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .start_len (start_len),
  .start_ilv (start_ilv),
  .stop      (stop),
  .col_valid (col_valid),
  .col_ready (col_ready),
  .col_addr  (col_addr),
  .col_last  (col_last),
  .start_err (start_err),
  .cur_full  (cur_full)
);

// File: tb/burst_col_seq_tb_top.sv
module burst_col_seq_tb_top;

  localparam int COL_W = 9;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [1:0]       start_len = 2'b00;
  logic             start_ilv = 1'b0;
  logic             stop = 1'b0;
  logic             col_ready = 1'b1;
  logic             col_valid;
  logic [COL_W-1:0] col_addr;
  logic             col_last;
  logic             start_err;

  int n_vec  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .start_col (start_col),
    .start_len (start_len),
    .start_ilv (start_ilv),
    .stop      (stop),
    .col_valid (col_valid),
    .col_ready (col_ready),
    .col_addr  (col_addr),
    .col_last  (col_last),
    .start_err (start_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected column from the requirement text, independent of the RTL.
  function automatic int model(int base, int code, bit ilv, int k);
    int n, blk, off;
    if (code == 3) return (base + k) % PAGE;
    n   = 2 << code;
    blk = base - (base % n);
    off = base % n;
    return ilv ? blk + (off ^ k) : blk + ((off + k) % n);
  endfunction

  // Raise start for one edge; returns at the falling edge after it.
  task automatic issue(input int col, input int code, input bit ilv);
    start_col = COL_W'(col);
    start_len = 2'(code);
    start_ilv = ilv;
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
  endtask

  // Check beats first..first+cnt-1 with ready high.
  task automatic run_beats(input string req, input int base, input int code,
                           input bit ilv, input int first, input int cnt);
    for (int k = first; k < first + cnt; k++) begin
      chk({req, " valid"}, int'(col_valid), 1);
      chk({req, " addr"}, int'(col_addr), model(base, code, ilv, k));
      chk({req, " last"}, int'(col_last),
          (code != 3 && k == (2 << code) - 1) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 valid", int'(col_valid), 0);
    chk("R1 last", int'(col_last), 0);
    chk("R1 err", int'(start_err), 0);
  endtask

  task automatic t_seq8();
    int exp_lo[8] = '{5, 6, 7, 0, 1, 2, 3, 4};
    issue(9'h1D5, 2, 1'b0);
    chk("R12 first", int'(col_addr), 9'h1D5);
    for (int k = 0; k < 8; k++) begin
      chk("R3 low", int'(col_addr[2:0]), exp_lo[k]);
      chk("R5 upper", int'(col_addr[8:3]), 9'h1D5 >> 3);
      chk("R7 last", int'(col_last), k == 7 ? 1 : 0);
      @(negedge clk);
    end
    chk("R7 idle after last", int'(col_valid), 0);
  endtask

  task automatic t_ilv();
    int exp_lo[8] = '{5, 4, 7, 6, 1, 0, 3, 2};
    issue(9'h0AD, 2, 1'b1);
    for (int k = 0; k < 8; k++) begin
      chk("R4 low8", int'(col_addr[2:0]), exp_lo[k]);
      chk("R5 upper", int'(col_addr[8:3]), 9'h0AD >> 3);
      @(negedge clk);
    end
    issue(9'h121, 1, 1'b1);
    run_beats("R4 len4", 9'h121, 1, 1'b1, 0, 4);
    chk("R7 end len4", int'(col_valid), 0);
    issue(9'h0FF, 0, 1'b0);
    run_beats("R2 len2", 9'h0FF, 0, 1'b0, 0, 2);
    chk("R2 end len2", int'(col_valid), 0);
  endtask

  task automatic t_page();
    issue(9'h1FC, 3, 1'b0);
    run_beats("R6 page", 9'h1FC, 3, 1'b0, 0, 7);
    chk("R6 still running", int'(col_valid), 1);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R11 page stop", int'(col_valid), 0);
  endtask

  task automatic t_stall();
    issue(9'h032, 1, 1'b0);
    run_beats("R10 pre", 9'h032, 1, 1'b0, 0, 1);
    col_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 hold valid", int'(col_valid), 1);
      chk("R10 hold addr", int'(col_addr), model(9'h032, 1, 1'b0, 1));
    end
    col_ready = 1'b1;
    run_beats("R10 resume", 9'h032, 1, 1'b0, 1, 3);
    chk("R10 end", int'(col_valid), 0);
  endtask

  task automatic t_refuse();
    issue(9'h044, 3, 1'b1);
    chk("R8 err set", int'(start_err), 1);
    chk("R8 no addr", int'(col_valid), 0);
    @(negedge clk);
    chk("R8 err one cycle", int'(start_err), 0);
    chk("R8 still idle", int'(col_valid), 0);
    issue(9'h10B, 2, 1'b0);
    run_beats("R8 pre", 9'h10B, 2, 1'b0, 0, 2);
    issue(9'h000, 3, 1'b1);
    chk("R8 err in burst", int'(start_err), 1);
    run_beats("R8 burst kept", 9'h10B, 2, 1'b0, 3, 5);
    chk("R8 end", int'(col_valid), 0);
  endtask

  task automatic t_abort();
    issue(9'h180, 2, 1'b1);
    run_beats("R9 old", 9'h180, 2, 1'b1, 0, 3);
    issue(9'h041, 0, 1'b0);
    run_beats("R9 new", 9'h041, 0, 1'b0, 0, 2);
    chk("R9 end", int'(col_valid), 0);
  endtask

  task automatic t_stop_fixed();
    issue(9'h0E3, 2, 1'b0);
    run_beats("R11 pre", 9'h0E3, 2, 1'b0, 0, 2);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R11 fixed stop", int'(col_valid), 0);
    chk("R11 last low", int'(col_last), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_seq8();
    t_ilv();
    t_page();
    t_stall();
    t_refuse();
    t_abort();
    t_stop_fixed();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule